// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Parallel Test Mode

This block is the device-side control of a small by-4 dynamic memory. It is modelled as a synthesizable cell array with a system clock. The row strobe, column strobe and write strobe are active-low and are sampled on every rising clock edge. A state machine sorts each row-strobe cycle into one of four kinds: an ordinary access, a refresh addressed from the pins with the column strobe held high, a refresh where the column strobe goes low before the row strobe, or a concealed refresh that keeps read data on the output. The two refresh kinds that ignore the address pins take their row from an internal counter.

A test mode is switched on and off through particular refresh cycles. While it is on, the two lowest column-address bits are ignored. A write then copies each data lane into four cells at once. A read reports, for each lane separately, whether those four cells agree. The kind of the current cycle, the test-mode flag and the refresh counter are brought out so that the decoding can be observed.

The state machine has these states. IDLE: row strobe released. ROW: row open, no column cycle yet. ACC: a column cycle is in progress. PAGE: row still open after a column cycle. HOLD: read data held with the row strobe released. REF: an internally addressed refresh. These are the transitions:
- IDLE to ROW on a row-strobe fall with the column strobe high.
- IDLE to REF on a row-strobe fall with the column strobe low.
- ROW or PAGE to ACC when the column strobe goes low.
- ACC to PAGE when the column strobe rises.
- ROW, PAGE or ACC to IDLE when the row strobe rises.
- ACC or REF to HOLD when the row strobe rises while read data is held under a low column strobe.
- HOLD to REF when the row strobe falls again.
- HOLD to IDLE when the column strobe rises.

Top module: `dram_cycle_ctl`

## Requirements
- R1: After reset, cyc_type is 0 (none), test_mode is 0, ref_row is 0 and dq_oe is 0.
- R2: A row-strobe fall with the column strobe high latches addr[ROW_BITS-1:0] as the row, and cyc_type becomes 5 (row open). A following column-strobe fall latches addr[COL_BITS-1:0] as the column and sets cyc_type to 1 (access). With we_n low, dq_in is stored in that cell. With we_n high, the stored word appears on dq_out with dq_oe high after that same edge.
- R3: Several column cycles may run while the row strobe stays low, and all of them use the latched row.
- R4: A row-strobe cycle with no column-strobe fall sets cyc_type to 2 (pin-addressed refresh) when the row strobe rises. It keeps dq_oe low, leaves the memory unchanged and clears test_mode.
- R5: A row-strobe fall while the column strobe is already low, with no read data held, sets cyc_type to 3 (strobe-order refresh). It ignores addr, changes no cell and increments ref_row by one.
- R6: A read whose column strobe stays low through a row-strobe rise and a new fall sets cyc_type to 4 (concealed refresh) and increments ref_row. dq_out and dq_oe stay unchanged until the column strobe rises.
- R7: ref_row counts modulo 2**ROW_BITS and changes only on the cycles of R5 and R6.
- R8: A strobe-order refresh with we_n low sets test_mode. One with we_n high clears it.
- R9: In test mode a write ignores column bits 1:0 and stores dq_in into all four cells that share column bits COL_BITS-1:2.
- R10: In test mode a read ignores column bits 1:0. dq_out[d] is 1 when bit d is equal in all four cells of the group and 0 otherwise.
- R11: dq_oe is low on the edge after one at which cas_n is sampled high.
- R12: cyc_type keeps its value until the next classifying event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, all strobes sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Multiplexed row / column address |
| dq_in | input | DQ_W | Write data lanes |
| dq_out | output | DQ_W | Read data or per-lane agree flags |
| dq_oe | output | 1 | Output drive enable for dq_out |
| cyc_type | output | 3 | Kind of the current or most recent cycle |
| test_mode | output | 1 | Parallel test mode active |
| ref_row | output | ROW_BITS | Internal refresh row counter |

## Verification
The bound checker watches these properties on every clock:
- The output enable falls after the column strobe rises, and it stays off through pin-addressed refresh.
- The test flag rises only on a strobe-order refresh with the write strobe low, and it falls only on one of the two exit cycles.
- The refresh counter moves only by one, and only just after a row-strobe fall under a low column strobe.
- A concealed refresh starts with data still driven.

Stored values, the compare result of a test read, the way the two low column bits are ignored, and page-mode row reuse all depend on earlier writes. Only the bench scenarios, run against a reference copy of the array, can show these.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;

    typedef enum logic [2:0] {
        CYC_NONE     = 3'd0,
        CYC_ACCESS   = 3'd1,
        CYC_RAS_ONLY = 3'd2,
        CYC_CBR      = 3'd3,
        CYC_HIDDEN   = 3'd4,
        CYC_ROW_WAIT = 3'd5
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_ACC  = 3'd2,
        ST_PAGE = 3'd3,
        ST_HOLD = 3'd4,
        ST_REF  = 3'd5
    } st_e;

endpackage

// File: rtl/dram_strobe_edge.sv
module dram_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    output logic ras_fall
);
    logic ras_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ras_q <= 1'b1;
        else        ras_q <= ras_n;
    end

    assign ras_fall = ras_q & ~ras_n;
endmodule

// File: rtl/dram_ref_ctr.sv
module dram_ref_ctr #(
    parameter int ROW_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    output logic [ROW_BITS-1:0] row_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)    row_q <= '0;
        else if (step) row_q <= row_q + 1'b1;
    end
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int ROW_BITS    = 3,
    parameter int COL_BITS    = 4,
    parameter int DQ_W        = 4,
    parameter int TM_IGN_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic                test_en,
    input  logic [ROW_BITS-1:0] row,
    input  logic [COL_BITS-1:0] col,
    input  logic [DQ_W-1:0]     wdata,
    output logic [DQ_W-1:0]     rdata
);
    localparam int IDX_W = ROW_BITS + COL_BITS;
    localparam int DEPTH = 1 << IDX_W;
    localparam int GRP   = 1 << TM_IGN_BITS;

    logic [DQ_W-1:0]  mem [DEPTH];
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] base;
    logic [DQ_W-1:0]  all_one;
    logic [DQ_W-1:0]  all_zero;

    assign idx  = {row, col};
    assign base = {row, col[COL_BITS-1:TM_IGN_BITS], {TM_IGN_BITS{1'b0}}};

    // per-lane agreement across the group of cells sharing the upper column bits
    always_comb begin
        for (int d = 0; d < DQ_W; d++) begin
            all_one[d]  = 1'b1;
            all_zero[d] = 1'b1;
            for (int k = 0; k < GRP; k++) begin
                all_one[d]  = all_one[d]  &  mem[base | IDX_W'(k)][d];
                all_zero[d] = all_zero[d] & ~mem[base | IDX_W'(k)][d];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (test_en) begin
                for (int k = 0; k < GRP; k++) begin
                    mem[base | IDX_W'(k)] <= wdata;
                end
            end else begin
                mem[idx] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= test_en ? (all_one | all_zero) : mem[idx];
    end
endmodule

// File: rtl/dram_cycle_ctl.sv
module dram_cycle_ctl
    import dram_cyc_pkg::*;
#(
    parameter int ROW_BITS    = 3,
    parameter int COL_BITS    = 4,
    parameter int DQ_W        = 4,
    parameter int TM_IGN_BITS = 2,
    parameter int ADDR_W      = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DQ_W-1:0]     dq_in,
    output logic [DQ_W-1:0]     dq_out,
    output logic                dq_oe,
    output logic [2:0]          cyc_type,
    output logic                test_mode,
    output logic [ROW_BITS-1:0] ref_row
);
    st_e                 st_q, st_d;
    cyc_e                cyc_q;
    logic                tm_q;
    logic                oe_q;
    logic [ROW_BITS-1:0] row_q;
    logic                ras_fall;
    logic                ev_row, ev_cbr, ev_hid, ev_acc, ev_ronly;
    logic                acc_rd, acc_wr;

    dram_strobe_edge i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .ras_fall (ras_fall)
    );

    dram_ref_ctr #(.ROW_BITS(ROW_BITS)) i_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ev_cbr | ev_hid),
        .row_q (ref_row)
    );

    dram_cell_array #(
        .ROW_BITS    (ROW_BITS),
        .COL_BITS    (COL_BITS),
        .DQ_W        (DQ_W),
        .TM_IGN_BITS (TM_IGN_BITS)
    ) i_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_wr),
        .rd_en   (acc_rd),
        .test_en (tm_q),
        .row     (row_q),
        .col     (addr[COL_BITS-1:0]),
        .wdata   (dq_in),
        .rdata   (dq_out)
    );

    // classifying events
    always_comb begin
        ev_row   = (st_q == ST_IDLE) && ras_fall && cas_n;
        ev_cbr   = (st_q == ST_IDLE) && ras_fall && !cas_n;
        ev_hid   = (st_q == ST_HOLD) && !cas_n && !ras_n;
        ev_acc   = ((st_q == ST_ROW) || (st_q == ST_PAGE)) && !ras_n && !cas_n;
        ev_ronly = (st_q == ST_ROW) && ras_n;
        acc_rd   = ev_acc && we_n;
        acc_wr   = ev_acc && !we_n;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ev_row)      st_d = ST_ROW;
                else if (ev_cbr) st_d = ST_REF;
            end
            ST_ROW: begin
                if (ras_n)       st_d = ST_IDLE;
                else if (!cas_n) st_d = ST_ACC;
            end
            ST_ACC: begin
                if (ras_n)       st_d = (!cas_n && oe_q) ? ST_HOLD : ST_IDLE;
                else if (cas_n)  st_d = ST_PAGE;
            end
            ST_PAGE: begin
                if (ras_n)       st_d = ST_IDLE;
                else if (!cas_n) st_d = ST_ACC;
            end
            ST_HOLD: begin
                if (cas_n)       st_d = ST_IDLE;
                else if (!ras_n) st_d = ST_REF;
            end
            ST_REF: begin
                if (ras_n)       st_d = (!cas_n && oe_q) ? ST_HOLD : ST_IDLE;
            end
            default:             st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs and latched row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= CYC_NONE;
            tm_q  <= 1'b0;
            oe_q  <= 1'b0;
            row_q <= '0;
        end else begin
            if (ev_row) begin
                cyc_q <= CYC_ROW_WAIT;
                row_q <= addr[ROW_BITS-1:0];
            end
            if (ev_cbr) begin
                cyc_q <= CYC_CBR;
                tm_q  <= ~we_n;
            end
            if (ev_hid)   cyc_q <= CYC_HIDDEN;
            if (ev_acc)   cyc_q <= CYC_ACCESS;
            if (ev_ronly) begin
                cyc_q <= CYC_RAS_ONLY;
                tm_q  <= 1'b0;
            end
            if (acc_rd)      oe_q <= 1'b1;
            else if (cas_n)  oe_q <= 1'b0;
            else if (acc_wr) oe_q <= 1'b0;
        end
    end

    assign cyc_type  = cyc_q;
    assign test_mode = tm_q;
    assign dq_oe     = oe_q;
endmodule

// File: rtl/dram_cycle_ctl_chk.sv
module dram_cycle_ctl_chk
    import dram_cyc_pkg::*;
#(
    parameter int ROW_BITS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ras_n,
    input logic                cas_n,
    input logic                we_n,
    input logic                dq_oe,
    input logic [2:0]          cyc_type,
    input logic                test_mode,
    input logic [ROW_BITS-1:0] ref_row
);
    AST_OE_AFTER_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cas_n) |-> !dq_oe); // R11

    AST_RONLY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_RAS_ONLY) |-> !dq_oe); // R4

    AST_RONLY_NO_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_RAS_ONLY) |-> !test_mode); // R4

    AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_row != $past(ref_row)) |->
            ($past(ras_n, 2) && !$past(ras_n) && !$past(cas_n) &&
             ref_row == ROW_BITS'($past(ref_row) + 1'b1))); // R7

    AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> (cyc_type == CYC_CBR && !$past(we_n))); // R8

    AST_TEST_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_mode) |-> (cyc_type == CYC_CBR || cyc_type == CYC_RAS_ONLY)); // R8

    AST_HIDDEN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_HIDDEN && $past(cyc_type) != CYC_HIDDEN) |-> dq_oe); // R6
endmodule

bind dram_cycle_ctl dram_cycle_ctl_chk #(.ROW_BITS(ROW_BITS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dq_oe     (dq_oe),
    .cyc_type  (cyc_type),
    .test_mode (test_mode),
    .ref_row   (ref_row)
);

// File: tb/test_dram_cycle_ctl.sv
module test_dram_cycle_ctl;
    localparam int ROWS = 8;
    localparam int COLS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [3:0] addr = '0;
    logic [3:0] dq_in = '0;
    logic [3:0] dq_out;
    logic       dq_oe;
    logic [2:0] cyc_type;
    logic       test_mode;
    logic [2:0] ref_row;

    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    bit   exp_tm = 0;
    int   exp_ref = 0;
    logic [3:0] mdl [ROWS*COLS];

    always #10 clk = ~clk;

    dram_cycle_ctl i_dram_cycle_ctl (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .cyc_type(cyc_type), .test_mode(test_mode), .ref_row(ref_row)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int gidx(input int row, input int col, input int k);
        return row * COLS + (col & ~3) + k;
    endfunction

    function automatic logic [3:0] exp_cmp(input int row, input int col);
        logic [3:0] r;
        for (int d = 0; d < 4; d++) begin
            logic ones, zeros;
            ones = 1'b1; zeros = 1'b1;
            for (int k = 0; k < 4; k++) begin
                ones  = ones  &  mdl[gidx(row, col, k)][d];
                zeros = zeros & ~mdl[gidx(row, col, k)][d];
            end
            r[d] = ones | zeros;
        end
        return r;
    endfunction

    function automatic logic [3:0] exp_read(input int row, input int col);
        return exp_tm ? exp_cmp(row, col) : mdl[row * COLS + col];
    endfunction

    task automatic do_write(input int row, input int col, input logic [3:0] v);
        ras_n = 0; addr = 4'(row); step();
        chk("R2 row open code", 32'(cyc_type), 5);
        addr = 4'(col); cas_n = 0; we_n = 0; dq_in = v; step();
        chk("R2 access code", 32'(cyc_type), 1);
        chk("R2 write oe", 32'(dq_oe), 0);
        if (exp_tm) begin
            for (int k = 0; k < 4; k++) mdl[gidx(row, col, k)] = v;   // R9
        end else begin
            mdl[row * COLS + col] = v;
        end
        ras_n = 1; cas_n = 1; we_n = 1; step();
    endtask

    task automatic do_read(input int row, input int col, input bit keep);
        logic [3:0] e;
        e = exp_read(row, col);
        ras_n = 0; addr = 4'(row); step();
        addr = 4'(col); cas_n = 0; we_n = 1; step();
        chk(exp_tm ? "R10 test compare" : "R2 read data", 32'(dq_out), 32'(e));
        chk("R2 read oe", 32'(dq_oe), 1);
        if (!keep) begin
            ras_n = 1; cas_n = 1; step();
            chk("R11 oe drops", 32'(dq_oe), 0);
        end
    endtask

    task automatic do_hidden(input int row, input int col);
        logic [3:0] e;
        e = exp_read(row, col);
        do_read(row, col, 1);
        ras_n = 1; step();
        chk("R6 hold oe", 32'(dq_oe), 1);
        for (int n = 0; n < 2; n++) begin
            ras_n = 0; addr = 4'($urandom_range(15)); step();
            exp_ref = (exp_ref + 1) % ROWS;
            chk("R6 hidden code", 32'(cyc_type), 4);
            chk("R6 counter", 32'(ref_row), 32'(exp_ref));
            chk("R6 data kept", 32'(dq_out), 32'(e));
            chk("R6 oe kept", 32'(dq_oe), 1);
            ras_n = 1; step();
        end
        cas_n = 1; step();
        chk("R11 oe after hidden", 32'(dq_oe), 0);
        chk("R12 code held", 32'(cyc_type), 4);
    endtask

    task automatic do_cbr(input bit w);
        cas_n = 0; step();
        ras_n = 0; we_n = w; addr = 4'($urandom_range(15)); step();
        exp_ref = (exp_ref + 1) % ROWS;
        exp_tm = !w;
        chk("R5 cbr code", 32'(cyc_type), 3);
        chk("R7 counter", 32'(ref_row), 32'(exp_ref));
        chk("R8 test flag", 32'(test_mode), 32'(exp_tm));
        chk("R5 oe low", 32'(dq_oe), 0);
        ras_n = 1; we_n = 1; step();
        cas_n = 1; step();
    endtask

    task automatic do_ras_only(input int row);
        ras_n = 0; addr = 4'(row); step();
        ras_n = 1; step();
        exp_tm = 0;
        chk("R4 ras-only code", 32'(cyc_type), 2);
        chk("R4 test cleared", 32'(test_mode), 0);
        chk("R4 oe low", 32'(dq_oe), 0);
        step();
        chk("R12 code held", 32'(cyc_type), 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) step();
        rst_n = 1; step();
        chk("R1 cyc", 32'(cyc_type), 0);
        chk("R1 test", 32'(test_mode), 0);
        chk("R1 ref", 32'(ref_row), 0);
        chk("R1 oe", 32'(dq_oe), 0);

        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                do_write(r, c, 4'($urandom_range(15)));
        for (int i = 0; i < 8; i++) do_read($urandom_range(7), $urandom_range(15), 0);

        // R3 page mode: write then read in one row cycle
        ras_n = 0; addr = 4'd6; step();
        addr = 4'd3; cas_n = 0; we_n = 0; dq_in = 4'hA; step();
        mdl[6 * COLS + 3] = 4'hA;
        cas_n = 1; we_n = 1; step();
        addr = 4'd3; cas_n = 0; step();
        chk("R3 page read", 32'(dq_out), 32'hA);
        cas_n = 1; step();
        addr = 4'd9; cas_n = 0; step();
        chk("R3 page row kept", 32'(dq_out), 32'(mdl[6 * COLS + 9]));
        ras_n = 1; cas_n = 1; step();

        do_ras_only(2);
        do_read(2, 5, 0);
        do_cbr(1);
        do_hidden(1, 7);

        // R8/R9/R10 test mode: agree then disagree
        do_cbr(0);
        do_write(3, 6, 4'h5);
        do_read(3, 4, 0);
        chk("R10 agree all", 32'(exp_cmp(3, 4)), 32'hF);
        do_ras_only(0);
        do_write(3, 5, 4'h4);
        do_cbr(0);
        do_read(3, 7, 0);
        do_cbr(1);
        do_read(3, 5, 0);

        // R7 wrap
        for (int i = 0; i < ROWS + 1; i++) do_cbr(1);

        for (int i = 0; i < 250; i++) begin
            int op;
            op = $urandom_range(5);
            case (op)
                0: do_write($urandom_range(7), $urandom_range(15), 4'($urandom_range(15)));
                1: do_read($urandom_range(7), $urandom_range(15), 0);
                2: do_cbr(1'($urandom_range(1)));
                3: do_ras_only($urandom_range(7));
                4: do_hidden($urandom_range(7), $urandom_range(15));
                default: do_read($urandom_range(7), $urandom_range(15), 0);
            endcase
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule